// File: doc/BRIEF.md
# Readback CRC Checksum Appender

This block watches a serial readback stream one bit per clock and keeps a running CRC-16 over every valid bit it sees. It uses the CCITT generator polynomial x^16 + x^12 + x^5 + 1 (0x1021). Data bits are forwarded to the serial output unchanged, one register stage later. When the stream is closed, the block appends a shortened checksum made of the eleven upper bits of the CRC register.

A start pulse opens a readback, clears the CRC register and arms the block. An end pulse closes the stream. The end pulse may share its cycle with the last valid data bit, and that bit is then still counted. After the eleven check bits, a single-cycle done flag marks the end of the frame. With done, a match flag reports whether the shortened checksum equals a previously stored 11-bit value supplied on an input.

The full 16-bit register is also visible at all times, so a system can compare the whole value with a stored one. The appended field covers only 11 bits, so about one corrupted stream in 2048 can produce a field equal to the stored one.

Top module: `rbck_appender`

## Requirements
- R1: While reset is high and in the cycle after it, the outputs dout_o, dout_vld_o, done_o and match_o are 0, and crc_o is 0.
- R2: A start pulse is seen at a clock edge. After that edge, crc_o is 0 and dout_vld_o is 0, whatever the block was doing before.
- R3: While the stream is open, each cycle with din_vld_i high puts din_i on dout_o with dout_vld_o high after the next edge. A cycle with din_vld_i low gives dout_vld_o low.
- R4: The CRC is updated once per valid data bit, MSB first, with feedback = crc[15] XOR bit and polynomial 0x1021, from a zero start. Over the ASCII bytes "123456789", each byte sent MSB first, the result is crc_o = 0x31C3.
- R5: In the 11 cycles after the stream closes, dout_o carries crc[15] down to crc[5], one bit per cycle, with dout_vld_o high. After that, dout_vld_o is low.
- R6: While the check bits are being shifted out, crc_o does not change, whatever the data inputs carry.
- R7: done_o is high for exactly one cycle, in the cycle that follows the eleventh check bit. In that cycle dout_vld_o is low.
- R8: In the done cycle, match_o is 1 exactly when crc_o[15:5] equals prev_sum_i.
- R9: From the done cycle until the next start pulse, data and end inputs are ignored: dout_vld_o stays low and crc_o keeps its value.
- R10: A start pulse that arrives while the check bits are being shifted out aborts them. The next stream is then handled from a zero CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a readback and clears the CRC |
| din_i | input | 1 | Serial readback data bit |
| din_vld_i | input | 1 | din_i carries a bit this cycle |
| end_i | input | 1 | Closes the stream (may coincide with the last valid bit) |
| prev_sum_i | input | 11 | Stored shortened checksum to compare against |
| dout_o | output | 1 | Serial output: forwarded data, then check bits |
| dout_vld_o | output | 1 | dout_o carries a bit this cycle |
| done_o | output | 1 | One-cycle pulse after the last check bit |
| match_o | output | 1 | Shortened checksum equals prev_sum_i (valid with done_o) |
| crc_o | output | 16 | Full running CRC register |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of the check-bit shift. At that moment the sequencer is mid-count and the CRC register holds a nonzero value. The stimulus closes a random stream, lets a few check bits out, and then pulses start. It then runs a new stream whose checksum is known, which shows that no leftover state survives. The random streams also toggle the data and end inputs during the shift and after done. They set prev_sum_i either to the expected field or to that field with one bit flipped, so the match flag is driven both ways.

// File: rtl/rbck_pkg.sv
package rbck_pkg;

    localparam int          CRC_W = 16;
    localparam int          CHK_W = 11;
    localparam logic [15:0] POLY  = 16'h1021;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STREAM = 2'd1,
        PH_SHIFT  = 2'd2,
        PH_FIN    = 2'd3
    } phase_e;

    typedef struct packed {
        logic bit_v;
        logic vld;
        logic done;
        logic match;
    } out_s;

    function automatic logic [CRC_W-1:0] crc_next(
        input logic [CRC_W-1:0] cur,
        input logic             b,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = cur[CRC_W-1] ^ b;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/rbck_crc_reg.sv
module rbck_crc_reg
    import rbck_pkg::*;
#(
    parameter int               W = CRC_W,
    parameter logic [CRC_W-1:0] P = POLY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         adv_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            crc_o <= '0;
        end else if (adv_i) begin
            crc_o <= crc_next(crc_o, bit_i, P);
        end
    end

    // R2: a clear leaves the register at zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (crc_o == '0));

    // R6: no advance means no change
    a_r6_hold_no_adv: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !clear_i) |=> $stable(crc_o));

endmodule

// File: rtl/rbck_seq.sv
module rbck_seq
    import rbck_pkg::*;
#(
    parameter int N_CHK = CHK_W,
    localparam int IDX_W = $clog2(N_CHK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             end_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CHK - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_IDLE;
            idx_o   <= '0;
        end else if (start_i) begin
            phase_o <= PH_STREAM;
            idx_o   <= '0;
        end else begin
            unique case (phase_o)
                PH_IDLE: begin
                    phase_o <= PH_IDLE;
                end
                PH_STREAM: begin
                    if (end_i) begin
                        phase_o <= PH_SHIFT;
                        idx_o   <= '0;
                    end
                end
                PH_SHIFT: begin
                    if (idx_o == LAST) begin
                        phase_o <= PH_FIN;
                    end else begin
                        idx_o <= idx_o + 1'b1;
                    end
                end
                PH_FIN: begin
                    phase_o <= PH_IDLE;
                end
                default: phase_o <= PH_IDLE;
            endcase
        end
    end

    // R5: the shift counter never passes the last check bit
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_SHIFT) |-> (idx_o <= LAST));

    // R7: the final phase lasts one cycle
    a_r7_fin_once: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_FIN) |=> (phase_o != PH_FIN));

endmodule

// File: rtl/rbck_out.sv
module rbck_out
    import rbck_pkg::*;
#(
    parameter int W     = CRC_W,
    parameter int N_CHK = CHK_W,
    localparam int IDX_W = $clog2(N_CHK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  phase_e           phase_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             din_i,
    input  logic             din_vld_i,
    input  logic [W-1:0]     crc_i,
    input  logic [N_CHK-1:0] prev_i,
    output out_s             out_o
);

    logic [N_CHK-1:0] field_w;
    logic             chk_bit_w;

    assign field_w   = crc_i[W-1 -: N_CHK];
    assign chk_bit_w = crc_i[W - 1 - int'(idx_i)];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.bit_v <= 1'b0;
            out_o.vld   <= 1'b0;
            out_o.done  <= 1'b0;
            if (start_i) begin
                out_o.match <= 1'b0;
            end else begin
                unique case (phase_i)
                    PH_STREAM: begin
                        if (din_vld_i) begin
                            out_o.bit_v <= din_i;
                            out_o.vld   <= 1'b1;
                        end
                    end
                    PH_SHIFT: begin
                        out_o.bit_v <= chk_bit_w;
                        out_o.vld   <= 1'b1;
                    end
                    PH_FIN: begin
                        out_o.done  <= 1'b1;
                        out_o.match <= (field_w == prev_i);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        out_o.done |=> !out_o.done);

    // R7: no data with done
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
        out_o.done |-> !out_o.vld);

    // R5: every shift cycle emits a bit
    a_r5_shift_valid: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_SHIFT && !start_i) |=> out_o.vld);

    // R9: idle emits nothing
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_IDLE) |=> !out_o.vld);

endmodule

// File: rtl/rbck_appender.sv
module rbck_appender
    import rbck_pkg::*;
#(
    parameter int               W     = CRC_W,
    parameter int               N_CHK = CHK_W,
    parameter logic [CRC_W-1:0] P     = POLY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             din_i,
    input  logic             din_vld_i,
    input  logic             end_i,
    input  logic [N_CHK-1:0] prev_sum_i,
    output logic             dout_o,
    output logic             dout_vld_o,
    output logic             done_o,
    output logic             match_o,
    output logic [W-1:0]     crc_o
);

    localparam int IDX_W = $clog2(N_CHK);

    phase_e           phase_w;
    logic [IDX_W-1:0] idx_w;
    logic             adv_w;
    out_s             out_w;

    assign adv_w = (phase_w == PH_STREAM) && din_vld_i && !start_i;

    rbck_crc_reg #(.W(W), .P(P)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_i),
        .adv_i   (adv_w),
        .bit_i   (din_i),
        .crc_o   (crc_o)
    );

    rbck_seq #(.N_CHK(N_CHK)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .end_i   (end_i),
        .phase_o (phase_w),
        .idx_o   (idx_w)
    );

    rbck_out #(.W(W), .N_CHK(N_CHK)) u_out (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .phase_i   (phase_w),
        .idx_i     (idx_w),
        .din_i     (din_i),
        .din_vld_i (din_vld_i),
        .crc_i     (crc_o),
        .prev_i    (prev_sum_i),
        .out_o     (out_w)
    );

    assign dout_o     = out_w.bit_v;
    assign dout_vld_o = out_w.vld;
    assign done_o     = out_w.done;
    assign match_o    = out_w.match;

    // R6: the register is frozen while check bits leave
    a_r6_crc_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_SHIFT && !start_i) |=> $stable(crc_o));

    // R9: the register is untouched between done and the next start
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_IDLE && !start_i) |=> $stable(crc_o));

endmodule

// File: tb/rbck_appender_test.sv
module rbck_appender_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, din_i, din_vld_i, end_i;
    logic [10:0] prev_sum_i;
    logic        dout_o, dout_vld_o, done_o, match_o;
    logic [15:0] crc_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    rbck_appender uut (
        .clk(clk), .rst(rst), .start_i(start_i), .din_i(din_i),
        .din_vld_i(din_vld_i), .end_i(end_i), .prev_sum_i(prev_sum_i),
        .dout_o(dout_o), .dout_vld_o(dout_vld_o), .done_o(done_o),
        .match_o(match_o), .crc_o(crc_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // CCITT update written as explicit taps at bits 0, 5 and 12
    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic b);
        logic [15:0] n;
        logic fb;
        fb = c[15] ^ b;
        n  = c << 1;
        n[0]  = fb;
        n[5]  = c[4]  ^ fb;
        n[12] = c[11] ^ fb;
        return n;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic s, input logic d, input logic v, input logic e);
        @(negedge clk);
        start_i = s; din_i = d; din_vld_i = v; end_i = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        check(crc_o == 16'h0, "R2 crc clear", crc_o, 0);
        check(dout_vld_o == 1'b0, "R2 vld low", dout_vld_o, 0);
    endtask

    // sends bits, returns expected crc; last valid bit carries end
    task automatic send_stream(input int n, input bit gappy, input bit fixed,
                               output logic [15:0] exp);
        int sent = 0;
        logic [71:0] pat = 72'h313233343536373839;
        exp = 16'h0;
        while (sent < n) begin
            logic v, d, e;
            v = gappy ? (($urandom % 4) != 0) : 1'b1;
            d = fixed ? pat[71 - sent] : 1'($urandom % 2);
            e = v && (sent == n - 1);
            tick(1'b0, d, v, e);
            check(dout_vld_o == v, "R3 vld", dout_vld_o, v);
            if (v) begin
                check(dout_o == d, "R3 data", dout_o, d);
                exp = ref_step(exp, d);
                sent++;
            end
        end
        check(crc_o == exp, "R4 crc", crc_o, exp);
    endtask

    task automatic shift_out(input logic [15:0] exp, input int upto);
        for (int k = 0; k < upto; k++) begin
            tick(1'b0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            check(dout_vld_o == 1'b1, "R5 vld", dout_vld_o, 1);
            check(dout_o == exp[15-k], "R5 check bit", dout_o, exp[15-k]);
            check(crc_o == exp, "R6 crc hold", crc_o, exp);
            check(done_o == 1'b0, "R7 no early done", done_o, 0);
        end
    endtask

    task automatic finish_frame(input logic [15:0] exp, input bit want_match);
        tick(1'b0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
        check(done_o == 1'b1, "R7 done", done_o, 1);
        check(dout_vld_o == 1'b0, "R7 vld low at done", dout_vld_o, 0);
        check(match_o == want_match, "R8 match", match_o, want_match);
        tick(1'b0, 1'($urandom % 2), 1'b1, 1'($urandom % 2));
        check(done_o == 1'b0, "R7 done single", done_o, 0);
        check(dout_vld_o == 1'b0, "R9 ignored vld", dout_vld_o, 0);
        check(crc_o == exp, "R9 crc kept", crc_o, exp);
        tick(1'b0, 1'b1, 1'b1, 1'b1);
        check(dout_vld_o == 1'b0, "R9 ignored vld 2", dout_vld_o, 0);
        check(crc_o == exp, "R9 crc kept 2", crc_o, exp);
    endtask

    task automatic frame(input int n, input bit gappy, input bit fixed, input bit mt);
        logic [15:0] exp;
        do_start();
        send_stream(n, gappy, fixed, exp);
        prev_sum_i = mt ? exp[15:5] : (exp[15:5] ^ (11'd1 << ($urandom % 11)));
        shift_out(exp, 11);
        finish_frame(exp, mt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!ended) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] e0;
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 0; din_i = 0; din_vld_i = 0; end_i = 0; prev_sum_i = '0;
        repeat (3) @(posedge clk);
        #1;
        check(dout_vld_o == 0 && done_o == 0 && match_o == 0 && dout_o == 0,
              "R1 outputs in reset", {dout_o, dout_vld_o, done_o, match_o}, 0);
        check(crc_o == 16'h0, "R1 crc in reset", crc_o, 0);
        @(negedge clk); rst = 1'b0;
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        check(dout_vld_o == 1'b0, "R1 idle after reset", dout_vld_o, 0);
        check(crc_o == 16'h0, "R1 crc after reset", crc_o, 0);

        // R4 known vector: "123456789" -> 0x31C3, field 0x18E
        do_start();
        send_stream(72, 1'b0, 1'b1, e0);
        check(crc_o == 16'h31C3, "R4 known value", crc_o, 16'h31C3);
        prev_sum_i = 11'h18E;
        shift_out(16'h31C3, 11);
        finish_frame(16'h31C3, 1'b1);

        // R10: start in mid-shift, then a clean known frame
        do_start();
        send_stream(20, 1'b1, 1'b0, e0);
        shift_out(e0, 4);
        do_start();
        check(done_o == 1'b0, "R10 no done after abort", done_o, 0);
        send_stream(72, 1'b1, 1'b1, e0);
        check(crc_o == 16'h31C3, "R10 clean restart", crc_o, 16'h31C3);
        prev_sum_i = 11'h18F;
        shift_out(16'h31C3, 11);
        finish_frame(16'h31C3, 1'b0);

        // single-bit stream
        frame(1, 1'b0, 1'b0, 1'b1);

        // random streams
        for (int i = 0; i < 40; i++) begin
            frame(1 + int'($urandom % 60), 1'b1, 1'b0, 1'(i % 2));
        end

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule